// File: doc/BRIEF.md
# Saturating Add-Subtract Unit with Sticky Saturation Flag

This block performs signed two's-complement arithmetic that never wraps. A request carries an opcode and two operands. The block returns the exact sum or difference when that value fits in the data width. When it does not fit, the result is pinned to the largest or smallest representable value.

Two of the four opcodes first double operand B. The doubling is itself saturating. The doubled value is then added to or subtracted from operand A, and that second step saturates again.

A single sticky bit records that saturation has occurred at some point. Any saturating step sets it. Non-saturating work never clears it. Only a write to the status word can change it otherwise: the write copies bit 27 of the written word into the flag. A neighbouring unit, for example a multiplier, can also raise the flag through a set request. That request takes precedence over a simultaneous status write.

Top module: `sat_alu`

## Requirements
- R1: With op_code 0 (add), res_data equals A + B when the signed sum fits in 32 bits.
- R2: A positive overflow produces 0x7FFFFFFF and a negative overflow produces 0x80000000, for every opcode and every step.
- R3: With op_code 1 (subtract), res_data equals A - B, saturated as in R2.
- R4: With op_code 2 (doubled add), res_data equals sat(A + sat(2*B)).
- R5: With op_code 3 (doubled subtract), res_data equals sat(A - sat(2*B)).
- R6: Any operation that saturates in any step sets the sticky flag. This includes a doubling step whose final result is in range.
- R7: An operation that does not saturate leaves the sticky flag at its previous value.
- R8: A status write (stat_wr high) loads the sticky flag from stat_wdata bit 27. All other bits of stat_wdata have no effect.
- R9: ext_set sets the sticky flag. When ext_set and stat_wr occur in the same cycle, the flag ends up set. A saturating operation also wins over a same-cycle status write.
- R10: res_valid is high exactly one clock after each cycle in which op_valid is high. res_data holds its value in cycles without an operation.
- R11: While rst_n is low, res_valid and sticky_flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 2 | 0 add, 1 subtract, 2 doubled add, 3 doubled subtract |
| opnd_a | input | 32 | Operand A, signed |
| opnd_b | input | 32 | Operand B, signed |
| ext_set | input | 1 | External request to set the sticky flag |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 32 | Status word; bit 27 is the sticky flag |
| res_valid | output | 1 | res_data carries a new result |
| res_data | output | 32 | Registered saturated result |
| sticky_flag | output | 1 | Sticky saturation flag |

## Verification
A result is due at the first rising edge after the cycle in which its operation was presented, so res_valid and res_data arrive one clock later. The sticky flag reflects every set, write and saturation from that same edge onward.

The driver applies stimulus at the falling edge. For every driven cycle it queues one expected entry, which holds the valid bit, the data and the flag value after that edge. The monitor removes one entry two nanoseconds after each rising edge. Each comparison therefore lands exactly one register stage after its stimulus, and idle cycles are checked as well as active ones.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_SUB  = 2'd1,
    OPC_DADD = 2'd2,
    OPC_DSUB = 2'd3
  } sat_op_e;

  // Position of the sticky bit inside the status word.
  localparam int unsigned STICKY_POS = 27;
endpackage

// File: rtl/sat_addsub.sv
// One saturating add or subtract step.
module sat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic         do_sub,
  output logic [W-1:0] out_y,
  output logic         out_sat
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext_x, ext_y, wide;

  always_comb begin
    ext_x = {in_x[W-1], in_x};
    ext_y = {in_y[W-1], in_y};
    wide  = do_sub ? (ext_x - ext_y) : (ext_x + ext_y);
    // The top two bits disagree exactly when the result does not fit in W bits.
    out_sat = wide[W] ^ wide[W-1];
    if (out_sat) out_y = wide[W] ? NEG_LIM : POS_LIM;
    else         out_y = wide[W-1:0];
  end
endmodule

// File: rtl/sat_datapath.sv
// Operand doubling stage followed by the main saturating step.
module sat_datapath #(
  parameter int unsigned W = 32
) (
  input  sat_alu_pkg::sat_op_e op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0]         y,
  output logic                 any_sat
);
  import sat_alu_pkg::*;

  logic [W-1:0] dbl_b, rhs;
  logic         dbl_sat, main_sat;
  logic         use_dbl, is_sub;

  always_comb begin
    use_dbl = (op == OPC_DADD) || (op == OPC_DSUB);
    is_sub  = (op == OPC_SUB)  || (op == OPC_DSUB);
  end

  sat_addsub #(.W(W)) u_double (
    .in_x   (b),
    .in_y   (b),
    .do_sub (1'b0),
    .out_y  (dbl_b),
    .out_sat(dbl_sat)
  );

  assign rhs = use_dbl ? dbl_b : b;

  sat_addsub #(.W(W)) u_main (
    .in_x   (a),
    .in_y   (rhs),
    .do_sub (is_sub),
    .out_y  (y),
    .out_sat(main_sat)
  );

  assign any_sat = main_sat | (use_dbl & dbl_sat);
endmodule

// File: rtl/sat_sticky_reg.sv
// Sticky saturation bit. A set request beats a status write.
module sat_sticky_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_req)    flag_d = 1'b1;
    else if (wr_en) flag_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              ext_set,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              sticky_flag
);
  import sat_alu_pkg::*;

  sat_op_e           op_sel;
  logic [DATA_W-1:0] dp_y;
  logic              dp_sat;
  logic              set_any;
  logic              unused_stat_bits;

  logic [DATA_W-1:0] data_d, data_q;
  logic              vld_d, vld_q;

  assign op_sel = sat_op_e'(op_code);
  assign unused_stat_bits = ^{stat_wdata[31:STICKY_POS+1], stat_wdata[STICKY_POS-1:0]};

  sat_datapath #(.W(DATA_W)) u_dp (
    .op     (op_sel),
    .a      (opnd_a),
    .b      (opnd_b),
    .y      (dp_y),
    .any_sat(dp_sat)
  );

  assign set_any = ext_set | (op_valid & dp_sat);

  sat_sticky_reg u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_any),
    .wr_en  (stat_wr),
    .wr_bit (stat_wdata[STICKY_POS]),
    .flag_q (sticky_flag)
  );

  // Result stage next state: the data register loads only on a valid operation.
  always_comb begin
    vld_d  = op_valid;
    data_d = op_valid ? dp_y : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = data_q;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              ext_set,
  input logic              stat_wr,
  input logic [31:0]       stat_wdata,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              sticky_flag
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));

  assert_ext_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set |=> sticky_flag);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !ext_set && !stat_wr) |=> $stable(sticky_flag));

  assert_write_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !ext_set && !op_valid) |=> (sticky_flag == $past(stat_wdata[27])));

  assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_flag) |-> $past(op_valid || ext_set || stat_wr));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .ext_set    (ext_set),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .sticky_flag(sticky_flag)
);

// File: tb/sat_alu_tb.sv
`timescale 1ns/1ps
module sat_alu_tb;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic        ext_set, stat_wr;
  logic [31:0] stat_wdata;
  logic        res_valid;
  logic [31:0] res_data;
  logic        sticky_flag;

  int n_checks = 0;
  int n_fails  = 0;
  logic model_sticky = 1'b0;
  bit done = 0;

  typedef struct {
    logic        vld;
    logic [31:0] data;
    logic        stk;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  sat_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ext_set(ext_set), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .res_valid(res_valid), .res_data(res_data),
    .sticky_flag(sticky_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [32:0] clamp(longint v);
    if (v > 64'sd2147483647)       return {1'b1, 32'h7FFF_FFFF};
    else if (v < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    else                           return {1'b0, v[31:0]};
  endfunction

  // Returns {saturated, result} from the arithmetic rules alone.
  function automatic logic [32:0] ref_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    logic [32:0] d, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op[1]) begin
      d  = clamp(2 * sb);
      sb = longint'($signed(d[31:0]));
    end else begin
      d = 33'd0;
    end
    r = op[0] ? clamp(sa - sb) : clamp(sa + sb);
    return {r[32] | d[32], r[31:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one cycle at the falling edge and queues the expected outcome.
  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic es, input logic wr,
                      input logic [31:0] wd, input string tag);
    logic [32:0] r;
    exp_t e;
    r = ref_op(op, a, b);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    ext_set = es; stat_wr = wr; stat_wdata = wd;
    if (es || (v && r[32])) model_sticky = 1'b1;
    else if (wr)            model_sticky = wd[27];
    e.vld = v; e.data = r[31:0]; e.stk = model_sticky; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 0; ext_set = 0; stat_wr = 0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    step(1'b1, op, a, b, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic wr_stat(input logic [31:0] wd, input string tag);
    step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b1, wd, tag);
  endtask

  // Monitor: compares one queued entry per clock, 2 ns after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " valid"}, {31'd0, res_valid}, {31'd0, e.vld});
      if (e.vld) check({e.tag, " data"}, res_data, e.data);
      check({e.tag, " sticky"}, {31'd0, sticky_flag}, {31'd0, e.stk});
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
    ext_set = 0; stat_wr = 0; stat_wdata = 0;
    #22;
    check("R11 reset valid", {31'd0, res_valid}, 32'd0);
    check("R11 reset sticky", {31'd0, sticky_flag}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    do_op(2'd0, 32'd5, 32'd7, "R1 R7 add in range");
    do_op(2'd0, 32'h7FFF_FFFF, 32'd1, "R2 R6 add positive clamp");
    do_op(2'd0, 32'd3, 32'd4, "R7 add keeps sticky");
    wr_stat(32'hF7FF_FFFF, "R8 write bit27 zero clears");
    do_op(2'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R2 add negative clamp");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd1, 32'h8000_0000, 32'd1, "R2 R3 sub negative clamp");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd1, 32'd10, 32'd3, "R3 sub in range");
    do_op(2'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 R3 sub positive clamp");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd2, 32'd100, 32'd20, "R4 doubled add");
    do_op(2'd2, 32'hC000_0000, 32'h5000_0000, "R4 R6 doubling step saturates only");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd2, 32'h7000_0000, 32'h1000_0000, "R2 R4 second step clamps");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd3, 32'd0, 32'h4000_0000, "R5 R6 doubled sub first step");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd3, 32'h8000_0000, 32'd1, "R5 doubled sub second step");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd3, 32'd50, 32'hFFFF_FFF6, "R5 doubled sub in range");
    wr_stat(32'h0800_0000, "R8 write bit27 one sets");
    wr_stat(32'h0, "R8 clear");
    step(1'b0, 2'd0, 0, 0, 1'b1, 1'b0, 32'h0, "R9 ext set alone");
    wr_stat(32'h0, "R8 clear");
    step(1'b0, 2'd0, 0, 0, 1'b1, 1'b1, 32'h0, "R9 ext set beats write");
    step(1'b1, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, 32'h0, "R9 saturation beats write");
    step(1'b0, 2'd0, 32'h1234, 32'h1, 1'b0, 1'b0, 32'h0, "R10 idle cycle");
    wr_stat(32'h0, "R8 clear");
    do_op(2'd2, 32'hFFFF_FFFF, 32'hC000_0000, "R4 doubling exactly min");
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 4 == 1) b = {b[31], 3'b000, b[27:0]};
      if (i % 7 == 0) wr_stat(32'h0, "R8 clear loop");
      do_op(2'(i % 4), a, b, "R1 R3 R4 R5 R6 R10 mixed");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
  end
endmodule